// File: doc/BRIEF.md
# Region Protection and Translation Unit

This block splits a 32-bit address space into eight equal 512 MB regions, picked by the top three address bits. Each region carries a 4-bit attribute code. A fixed decoding turns that code into read, write and execute grants and a cache policy. A lookup presents an address and an access kind. In the same cycle the block returns the physical address, the grants, the cache policy and, when the kind is not granted, a prohibition fault with a cause code.

Two parameters choose the variant. In table mode (`CA_MODE = 0`) each region has its own attribute entry, written through an entry port. When `XLATE_EN = 1` the entry also holds a 3-bit physical region base, so a region can be relocated. In cache-attribute mode (`CA_MODE = 1`) a single 32-bit register supplies the attributes, one nibble per region, and addresses pass through unchanged. A read port returns the base and the attribute of any region.

Top module: `rpu_region_unit`

## Requirements
- R1: The region index is `lk_addr[31:29]`. `lk_paddr` is the region's 3-bit base placed in bits 31:29, with `lk_addr[28:0]` copied into the low bits.
- R2: After reset, region i has base i (identity mapping) and attribute 2.
- R3: When `wr_en` is high at a clock edge, the region `wr_addr[31:29]` takes `wr_data[3:0]` as its attribute. With translation enabled it also takes `wr_data[31:29]` as its base.
- R4: Attribute decoding gives `lk_perm` = {exec, write, read} and `lk_cache` (0 none, 1 bypass, 2 write-through, 3 write-back, 4 isolate). Code 0 gives read/write with write-through. Code 1 gives read/write/execute with write-through. Code 2 gives read/write/execute with bypass. Code 3 gives execute only with write-back. Codes 4 and 5 give read/write/execute with write-back. Code 14 gives read/write with isolate. Every other code gives no grant and cache 0.
- R5: In cache-attribute mode the region's code is `ca_q[4*i+3:4*i]` for region i. A write with `ca_wr_en` loads `ca_wr_data` at the clock edge. The register resets to 0x22222222. Code 5 gives no grant and cache 0 in this mode.
- R6: `lk_kind` 0 is a load, 1 is a store, and 2 or 3 is a fetch. A load needs read, a store needs write and a fetch needs execute. If the needed grant is missing, `lk_fault` is 1 and `lk_cause` is 1 (load), 2 (store) or 3 (fetch). Otherwise `lk_fault` is 0 and `lk_cause` is 0.
- R7: `rd_base` is the base of region `rd_addr[31:29]` in bits 31:29, with zeros below. `rd_entry` is the same base ORed with the region's code in bits 3:0.
- R8: The lookup is combinational: the outputs reflect `lk_addr` and `lk_kind` in the same cycle, and they reflect a write from the first cycle after its clock edge.
- R9: In cache-attribute mode, entry-port writes change neither lookups nor the read port.
- R10: With translation disabled, `wr_data[31:29]` is ignored. Every region keeps its identity base, and `lk_paddr` equals `lk_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | 32 | Entry write address; bits 31:29 select the region |
| wr_data | input | 32 | Entry write data; bits 31:29 base, bits 3:0 attribute |
| ca_wr_en | input | 1 | Cache attribute register write strobe |
| ca_wr_data | input | 32 | Cache attribute register write value |
| lk_addr | input | 32 | Lookup address |
| lk_kind | input | 2 | Lookup access kind |
| lk_paddr | output | 32 | Translated address |
| lk_perm | output | 3 | Grants {exec, write, read} |
| lk_cache | output | 3 | Cache policy code |
| lk_fault | output | 1 | Access prohibited |
| lk_cause | output | 2 | Prohibition cause |
| rd_addr | input | 32 | Read port address; bits 31:29 select the region |
| rd_base | output | 32 | Region base |
| rd_entry | output | 32 | Region base ORed with attribute |

## Verification
On every cycle, the assertions check four things: the offset bits pass through untranslated, a fault always lacks the grant for its kind and carries the matching cause, an entry or register write lands exactly where it was aimed, and with translation off the physical address equals the lookup address. The bench scenarios are the only way to show that the attribute decoding is right code by code, including the different meaning of code 5 in the two modes. They also show the identity reset of all eight regions and that entry writes in cache-attribute mode leave the visible state alone. Three configurations are driven from the same stimulus and compared against a bench model.

// File: rtl/rpu_pkg.sv
// Shared types for the region protection unit.
// Assumes a fixed 4-bit attribute code and a 2-bit access kind.
package rpu_pkg;

    localparam int unsigned RPU_ADDR_W   = 32;
    localparam int unsigned RPU_REG_BITS = 3;
    localparam int unsigned RPU_ATTR_W   = 4;

    // Access kind; code 3 is treated as a fetch.
    typedef enum logic [1:0] {
        KIND_LOAD   = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_FETCH  = 2'd2,
        KIND_FETCH2 = 2'd3
    } kind_e;

    // Cache policy reported with every lookup.
    typedef enum logic [2:0] {
        CP_NONE    = 3'd0,
        CP_BYPASS  = 3'd1,
        CP_WTHRU   = 3'd2,
        CP_WBACK   = 3'd3,
        CP_ISOLATE = 3'd4
    } cache_e;

    // Prohibition cause.
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LOAD  = 2'd1,
        CAUSE_STORE = 2'd2,
        CAUSE_FETCH = 2'd3
    } cause_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

endpackage

// File: rtl/rpu_attr_decode.sv
// Attribute decoder: turns a 4-bit region code into grants and cache policy.
// Assumes: CA_MODE selects the cache-attribute register meaning, where
// code 5 grants nothing. Purely combinational.
module rpu_attr_decode
    import rpu_pkg::*;
#(
    parameter bit          CA_MODE = 1'b0,
    parameter int unsigned ATTR_W  = RPU_ATTR_W
) (
    input  logic [ATTR_W-1:0] code,
    output perm_t             perm,
    output cache_e            cache
);

    localparam int unsigned NCODES = 1 << ATTR_W;

    // Map each code to grants and cache policy.
    always_comb begin
        perm  = '0;
        cache = CP_NONE;
        if (int'(code) < NCODES) begin
            case (code)
                4'd0:  begin perm = '{x:1'b0, w:1'b1, r:1'b1}; cache = CP_WTHRU;   end
                4'd1:  begin perm = '{x:1'b1, w:1'b1, r:1'b1}; cache = CP_WTHRU;   end
                4'd2:  begin perm = '{x:1'b1, w:1'b1, r:1'b1}; cache = CP_BYPASS;  end
                4'd3:  begin perm = '{x:1'b1, w:1'b0, r:1'b0}; cache = CP_WBACK;   end
                4'd4:  begin perm = '{x:1'b1, w:1'b1, r:1'b1}; cache = CP_WBACK;   end
                4'd5:  begin
                    if (!CA_MODE) begin
                        perm  = '{x:1'b1, w:1'b1, r:1'b1};
                        cache = CP_WBACK;
                    end
                end
                4'd14: begin perm = '{x:1'b0, w:1'b1, r:1'b1}; cache = CP_ISOLATE; end
                default: begin perm = '0; cache = CP_NONE; end
            endcase
        end
    end

endmodule

// File: rtl/rpu_region_table.sv
// Per-region entry storage: attribute and, when XLATE_EN, a physical base.
// Assumes one write port and two combinational read ports (lookup, read-back).
// Without translation the base is the region index itself.
module rpu_region_table
    import rpu_pkg::*;
#(
    parameter int unsigned REG_BITS   = RPU_REG_BITS,
    parameter int unsigned ATTR_W     = RPU_ATTR_W,
    parameter bit          XLATE_EN   = 1'b1,
    parameter int unsigned RESET_ATTR = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_BITS-1:0] wr_region,
    input  logic [REG_BITS-1:0] wr_base,
    input  logic [ATTR_W-1:0]   wr_attr,
    input  logic [REG_BITS-1:0] lk_region,
    output logic [REG_BITS-1:0] lk_base,
    output logic [ATTR_W-1:0]   lk_attr,
    input  logic [REG_BITS-1:0] rd_region,
    output logic [REG_BITS-1:0] rd_base,
    output logic [ATTR_W-1:0]   rd_attr
);

    localparam int unsigned NREG = 1 << REG_BITS;

    logic [ATTR_W-1:0] attr_q [NREG];

    // Attribute storage: reset to the default code, then per-region writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) attr_q[i] <= ATTR_W'(RESET_ATTR);
        end else if (wr_en) begin
            attr_q[wr_region] <= wr_attr;
        end
    end

    assign lk_attr = attr_q[lk_region];
    assign rd_attr = attr_q[rd_region];

    // R3: a written attribute is visible in the following cycle.
    a_r3_attr_update: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> attr_q[$past(wr_region)] == $past(wr_attr));

    generate
        if (XLATE_EN) begin : g_xlate
            logic [REG_BITS-1:0] base_q [NREG];

            // Base storage: identity at reset, replaced by writes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < NREG; i++) base_q[i] <= REG_BITS'(i);
                end else if (wr_en) begin
                    base_q[wr_region] <= wr_base;
                end
            end

            assign lk_base = base_q[lk_region];
            assign rd_base = base_q[rd_region];

            // R3: a written base is visible in the following cycle.
            a_r3_base_update: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> base_q[$past(wr_region)] == $past(wr_base));
        end else begin : g_ident
            logic unused_wr_base;
            assign unused_wr_base = ^wr_base;
            assign lk_base = lk_region;
            assign rd_base = rd_region;
        end
    endgenerate

endmodule

// File: rtl/rpu_cacheattr_reg.sv
// Single cache-attribute register: one attribute nibble per region.
// Assumes a whole-register write; reset fills every nibble with RESET_ATTR.
module rpu_cacheattr_reg
    import rpu_pkg::*;
#(
    parameter int unsigned REG_BITS   = RPU_REG_BITS,
    parameter int unsigned ATTR_W     = RPU_ATTR_W,
    parameter int unsigned RESET_ATTR = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [(ATTR_W<<REG_BITS)-1:0]     wr_data,
    input  logic [REG_BITS-1:0]               lk_region,
    output logic [ATTR_W-1:0]                 lk_attr,
    input  logic [REG_BITS-1:0]               rd_region,
    output logic [ATTR_W-1:0]                 rd_attr
);

    localparam int unsigned NREG  = 1 << REG_BITS;
    localparam int unsigned CA_W  = ATTR_W * NREG;

    function automatic logic [CA_W-1:0] reset_value();
        logic [CA_W-1:0] v;
        v = '0;
        for (int i = 0; i < NREG; i++) v[i*ATTR_W +: ATTR_W] = ATTR_W'(RESET_ATTR);
        return v;
    endfunction

    localparam logic [CA_W-1:0] CA_RESET = reset_value();

    logic [CA_W-1:0] ca_q;

    // Register update: reset pattern, then full-width writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     ca_q <= CA_RESET;
        else if (wr_en) ca_q <= wr_data;
    end

    assign lk_attr = ca_q[lk_region*ATTR_W +: ATTR_W];
    assign rd_attr = ca_q[rd_region*ATTR_W +: ATTR_W];

    // R5: a register write lands whole in the next cycle.
    a_r5_ca_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ca_q == $past(wr_data));

endmodule

// File: rtl/rpu_access_check.sv
// Access checker: compares the needed grant for an access kind with the
// region grants and produces the fault flag and cause. Combinational.
module rpu_access_check
    import rpu_pkg::*;
(
    input  perm_t        perm,
    input  logic [1:0]   kind,
    output logic         fault,
    output cause_e       cause
);

    // Pick the grant the kind needs and the cause it would raise.
    always_comb begin
        logic   granted;
        cause_e deny;
        case (kind_e'(kind))
            KIND_LOAD:  begin granted = perm.r; deny = CAUSE_LOAD;  end
            KIND_STORE: begin granted = perm.w; deny = CAUSE_STORE; end
            default:    begin granted = perm.x; deny = CAUSE_FETCH; end
        endcase
        fault = !granted;
        cause = granted ? CAUSE_NONE : deny;
    end

endmodule

// File: rtl/rpu_region_unit.sv
// Region protection and translation unit (top).
// Eight (2**REG_BITS) fixed regions selected by the top address bits.
// CA_MODE=1: attributes from one cache-attribute register, identity mapping.
// CA_MODE=0: per-region attribute table; XLATE_EN adds a relocatable base.
// Assumes the lookup path is combinational and writes take one clock edge.
module rpu_region_unit
    import rpu_pkg::*;
#(
    parameter bit          CA_MODE    = 1'b0,
    parameter bit          XLATE_EN   = 1'b1,
    parameter int unsigned ADDR_W     = RPU_ADDR_W,
    parameter int unsigned REG_BITS   = RPU_REG_BITS,
    parameter int unsigned ATTR_W     = RPU_ATTR_W,
    parameter int unsigned RESET_ATTR = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [ADDR_W-1:0]             wr_data,
    input  logic                          ca_wr_en,
    input  logic [(ATTR_W<<REG_BITS)-1:0] ca_wr_data,
    input  logic [ADDR_W-1:0]             lk_addr,
    input  logic [1:0]                    lk_kind,
    output logic [ADDR_W-1:0]             lk_paddr,
    output logic [2:0]                    lk_perm,
    output logic [2:0]                    lk_cache,
    output logic                          lk_fault,
    output logic [1:0]                    lk_cause,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [ADDR_W-1:0]             rd_base,
    output logic [ADDR_W-1:0]             rd_entry
);

    localparam int unsigned OFS_W = ADDR_W - REG_BITS;

    logic [REG_BITS-1:0] lk_region, rd_region, wr_region, wr_base;
    logic [REG_BITS-1:0] lk_base, rd_base_r;
    logic [ATTR_W-1:0]   lk_attr, wr_attr, rd_attr;
    perm_t               perm;
    cache_e              cache;
    cause_e              cause;

    assign lk_region = lk_addr[ADDR_W-1 -: REG_BITS];
    assign rd_region = rd_addr[ADDR_W-1 -: REG_BITS];
    assign wr_region = wr_addr[ADDR_W-1 -: REG_BITS];
    assign wr_base   = wr_data[ADDR_W-1 -: REG_BITS];
    assign wr_attr   = wr_data[ATTR_W-1:0];

    logic unused_bits;
    assign unused_bits = ^{wr_addr[OFS_W-1:0], wr_data[OFS_W-1:ATTR_W],
                           rd_addr[OFS_W-1:0], wr_en, ca_wr_en, ca_wr_data};

    generate
        if (CA_MODE) begin : g_ca
            rpu_cacheattr_reg #(
                .REG_BITS  (REG_BITS),
                .ATTR_W    (ATTR_W),
                .RESET_ATTR(RESET_ATTR)
            ) u_cattr (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (ca_wr_en),
                .wr_data  (ca_wr_data),
                .lk_region(lk_region),
                .lk_attr  (lk_attr),
                .rd_region(rd_region),
                .rd_attr  (rd_attr)
            );
            assign lk_base   = lk_region;
            assign rd_base_r = rd_region;
        end else begin : g_tbl
            rpu_region_table #(
                .REG_BITS  (REG_BITS),
                .ATTR_W    (ATTR_W),
                .XLATE_EN  (XLATE_EN),
                .RESET_ATTR(RESET_ATTR)
            ) u_table (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .wr_region(wr_region),
                .wr_base  (wr_base),
                .wr_attr  (wr_attr),
                .lk_region(lk_region),
                .lk_base  (lk_base),
                .lk_attr  (lk_attr),
                .rd_region(rd_region),
                .rd_base  (rd_base_r),
                .rd_attr  (rd_attr)
            );
        end
    endgenerate

    rpu_attr_decode #(
        .CA_MODE(CA_MODE),
        .ATTR_W (ATTR_W)
    ) u_decode (
        .code (lk_attr),
        .perm (perm),
        .cache(cache)
    );

    rpu_access_check u_check (
        .perm (perm),
        .kind (lk_kind),
        .fault(lk_fault),
        .cause(cause)
    );

    // Output assembly: base above untouched offset; read-back fields.
    assign lk_paddr = {lk_base, lk_addr[OFS_W-1:0]};
    assign lk_perm  = perm;
    assign lk_cache = cache;
    assign lk_cause = cause;
    assign rd_base  = {rd_base_r, {OFS_W{1'b0}}};
    assign rd_entry = {rd_base_r, {(OFS_W-ATTR_W){1'b0}}, rd_attr};

    // R1: offset bits are never translated.
    a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        lk_paddr[OFS_W-1:0] == lk_addr[OFS_W-1:0]);

    // R6: a fault always lacks the grant the kind needs.
    a_r6_fault_denied: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> ((lk_kind == 2'd0) ? !lk_perm[0] :
                      (lk_kind == 2'd1) ? !lk_perm[1] : !lk_perm[2]));

    // R6: the cause matches the access kind when faulting, else zero.
    a_r6_cause_kind: assert property (@(posedge clk) disable iff (!rst_n)
        lk_cause == (!lk_fault ? 2'd0 :
                     (lk_kind == 2'd0) ? 2'd1 :
                     (lk_kind == 2'd1) ? 2'd2 : 2'd3));

    generate
        if (!XLATE_EN || CA_MODE) begin : g_ident_chk
            // R10: without translation the address passes through whole.
            a_r10_identity: assert property (@(posedge clk) disable iff (!rst_n)
                lk_paddr == lk_addr);
        end
    endgenerate

endmodule

// File: tb/rpu_region_unit_bench.sv
// Bench for rpu_region_unit: three configurations driven in parallel
// (table with translation, table without, cache-attribute register)
// against a bench model. Directed corners, then seeded random traffic.
module rpu_region_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0, wr_data = '0;
    logic        ca_wr_en = 1'b0;
    logic [31:0] ca_wr_data = '0;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_kind = '0;
    logic [31:0] rd_addr = '0;

    logic [31:0] pa_x, pa_n, pa_c, rb_x, rb_n, rb_c, re_x, re_n, re_c;
    logic [2:0]  pm_x, pm_n, pm_c, ch_x, ch_n, ch_c;
    logic        ft_x, ft_n, ft_c;
    logic [1:0]  cs_x, cs_n, cs_c;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [2:0] m_base [8];
    logic [3:0] m_attr [8];
    logic [31:0] m_ca;

    always #5 clk = ~clk;

    rpu_region_unit #(.CA_MODE(1'b0), .XLATE_EN(1'b1)) u_rpu_region_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ca_wr_en(ca_wr_en), .ca_wr_data(ca_wr_data), .lk_addr(lk_addr), .lk_kind(lk_kind),
        .lk_paddr(pa_x), .lk_perm(pm_x), .lk_cache(ch_x), .lk_fault(ft_x), .lk_cause(cs_x),
        .rd_addr(rd_addr), .rd_base(rb_x), .rd_entry(re_x));

    rpu_region_unit #(.CA_MODE(1'b0), .XLATE_EN(1'b0)) u_rpu_region_unit_nx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ca_wr_en(ca_wr_en), .ca_wr_data(ca_wr_data), .lk_addr(lk_addr), .lk_kind(lk_kind),
        .lk_paddr(pa_n), .lk_perm(pm_n), .lk_cache(ch_n), .lk_fault(ft_n), .lk_cause(cs_n),
        .rd_addr(rd_addr), .rd_base(rb_n), .rd_entry(re_n));

    rpu_region_unit #(.CA_MODE(1'b1), .XLATE_EN(1'b0)) u_rpu_region_unit_ca (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ca_wr_en(ca_wr_en), .ca_wr_data(ca_wr_data), .lk_addr(lk_addr), .lk_kind(lk_kind),
        .lk_paddr(pa_c), .lk_perm(pm_c), .lk_cache(ch_c), .lk_fault(ft_c), .lk_cause(cs_c),
        .rd_addr(rd_addr), .rd_base(rb_c), .rd_entry(re_c));

    // R4/R5: expected grants {x,w,r} per code and mode.
    function automatic logic [2:0] exp_perm(input logic [3:0] c, input bit ca);
        case (c)
            4'd0, 4'd14: return 3'b011;
            4'd1, 4'd2, 4'd4: return 3'b111;
            4'd3: return 3'b100;
            4'd5: return ca ? 3'b000 : 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    // R4/R5: expected cache policy per code and mode.
    function automatic logic [2:0] exp_cache(input logic [3:0] c, input bit ca);
        case (c)
            4'd0, 4'd1: return 3'd2;
            4'd2: return 3'd1;
            4'd3, 4'd4: return 3'd3;
            4'd5: return ca ? 3'd0 : 3'd3;
            4'd14: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // R1/R4/R6: compare one configuration's lookup against the model.
    task automatic chk_one(input string req, input string tag, input logic [2:0] base,
                           input logic [3:0] code, input bit ca,
                           input logic [31:0] pa, input logic [2:0] pm,
                           input logic [2:0] ch, input logic ft, input logic [1:0] cs);
        logic [2:0] p;
        logic g;
        logic [1:0] ec;
        p = exp_perm(code, ca);
        g = (lk_kind == 2'd0) ? p[0] : (lk_kind == 2'd1) ? p[1] : p[2];
        ec = g ? 2'd0 : (lk_kind == 2'd0) ? 2'd1 : (lk_kind == 2'd1) ? 2'd2 : 2'd3;
        cmp(req, {tag, " paddr"}, pa, {base, lk_addr[28:0]});
        cmp(req, {tag, " perm"}, 32'(pm), 32'(p));
        cmp(req, {tag, " cache"}, 32'(ch), 32'(exp_cache(code, ca)));
        cmp(req, {tag, " fault"}, 32'(ft), 32'(!g));
        cmp(req, {tag, " cause"}, 32'(cs), 32'(ec));
    endtask

    // R8: lookup sampled in the same cycle the request is driven.
    task automatic lookup(input string req, input logic [31:0] a, input logic [1:0] k);
        logic [2:0] r;
        @(negedge clk);
        lk_addr = a;
        lk_kind = k;
        #1;
        r = a[31:29];
        chk_one(req, "xl", m_base[r], m_attr[r], 1'b0, pa_x, pm_x, ch_x, ft_x, cs_x);
        chk_one({req, " R10"}, "nx", r, m_attr[r], 1'b0, pa_n, pm_n, ch_n, ft_n, cs_n);
        chk_one({req, " R5"}, "ca", r, m_ca[r*4 +: 4], 1'b1, pa_c, pm_c, ch_c, ft_c, cs_c);
    endtask

    // R7: read port of all three configurations.
    task automatic readback(input string req, input logic [31:0] a);
        logic [2:0] r;
        @(negedge clk);
        rd_addr = a;
        #1;
        r = a[31:29];
        cmp(req, "xl rd_base", rb_x, {m_base[r], 29'd0});
        cmp(req, "xl rd_entry", re_x, {m_base[r], 25'd0, m_attr[r]});
        cmp({req, " R10"}, "nx rd_entry", re_n, {r, 25'd0, m_attr[r]});
        cmp({req, " R9"}, "ca rd_entry", re_c, {r, 25'd0, m_ca[r*4 +: 4]});
        cmp(req, "ca rd_base", rb_c, {r, 29'd0});
    endtask

    // R3: entry write through the port, one clock edge.
    task automatic entry_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_base[a[31:29]] = d[31:29];
        m_attr[a[31:29]] = d[3:0];
    endtask

    // R5: cache-attribute register write.
    task automatic ca_write(input logic [31:0] d);
        @(negedge clk);
        ca_wr_en = 1'b1; ca_wr_data = d;
        @(negedge clk);
        ca_wr_en = 1'b0;
        m_ca = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        for (int i = 0; i < 8; i++) begin m_base[i] = 3'(i); m_attr[i] = 4'd2; end
        m_ca = 32'h22222222;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state of every region, all configurations.
        for (int i = 0; i < 8; i++) begin
            readback("R2", {3'(i), 29'h0ABC});
            lookup("R2", {3'(i), 29'h1234567}, 2'(i % 4));
        end

        // R4: every code through region 3, every kind.
        for (int c = 0; c < 16; c++) begin
            entry_write({3'd3, 29'h5}, {3'd6, 25'h1FFFFFF, 4'(c)});
            for (int k = 0; k < 4; k++) lookup("R4 R6", {3'd3, 29'h1FFFFFFF}, 2'(k));
        end

        // R3/R1: relocation and R9: entry writes invisible to register mode.
        entry_write({3'd0, 29'h0}, {3'd7, 29'h0, 4'd14});
        entry_write({3'd7, 29'h0}, {3'd0, 29'h0, 4'd3});
        lookup("R1 R3", 32'h0000_0040, 2'd1);
        lookup("R1 R3", 32'hE000_0004, 2'd2);
        readback("R3 R7 R9", 32'h0000_0000);
        readback("R3 R7", 32'hFFFF_FFFF);

        // R5: register nibbles including code 5 and the top region.
        ca_write(32'h5E34_1052);
        for (int i = 0; i < 8; i++)
            for (int k = 0; k < 4; k++) lookup("R5", {3'(i), 29'h0}, 2'(k));
        readback("R5 R7", 32'hE000_0000);

        // R8: write then lookup on the very next cycle.
        entry_write({3'd2, 29'h0}, {3'd5, 25'h0, 4'd3});
        lookup("R8", 32'h4000_1000, 2'd0);

        // Random traffic.
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: entry_write($urandom(), $urandom());
                1: ca_write($urandom());
                2: lookup("R1 R4 R6", $urandom(), 2'($urandom_range(0, 3)));
                default: readback("R7", $urandom());
            endcase
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule